// File: doc/BRIEF.md
# SPI memory phase sequencer

This block runs one serial flash transaction from a single request. The transaction passes through up to four stages in a fixed order: command byte, address, dummy and data. The command byte is always one byte on one line. The request sets the length of each of the other stages, and it sets how many IO lines (1, 2 or 4) each of them uses. The command stage can therefore run on one line while the address, dummy and data stages that follow run on two or four lines. An address stage with zero bytes, a dummy stage with zero bytes and a data stage with no direction are skipped outright. This is how plain commands such as reset or write-enable are issued.

The block owns chip select, the serial clock and four bidirectional IO lines, each split into an output value, an output enable and an input. Transmit bytes come in on a valid/ready stream. Each transmit byte is taken when its first bit is about to be placed on the lines. Received bytes go out through a one-entry valid/ready stage. When either stream cannot keep up, the serial clock stops low at a byte boundary and chip select stays asserted. The interface runs in SPI mode 0, and the serial clock half-period is a parameter counted in system clocks.

Top module: `qspi_phase_seq`

## Requirements
- R1: After reset cs_n is 1, sck is 0, io_oe is 0, busy is 0, rx_valid is 0 and req_ready is 1.
- R2: The command byte is sent first, on one line, most significant bit first, on io_o[0] with io_oe = 4'b0001.
- R3: The address stage sends the low req_addr_bytes bytes of req_addr (0 to 3), most significant byte first. It uses the line width coded in req_addr_lanes (0 = one line, 1 = two lines, 2 = four lines). A count of 0 produces no clocks for this stage.
- R4: The dummy stage gives req_dummy_bytes × 8 / width clocks at the width coded in req_dummy_lanes, with io_oe = 0 on every clock.
- R5: For req_dir = 2 (write), the block takes req_data_len bytes from the transmit stream in order. One line sends bit 7 first on io_o[0]. Two lines send bits 7:6 first on io_o[1:0]. Four lines send bits 7:4 first on io_o[3:0]. io_oe covers exactly the lines in use.
- R6: For req_dir = 1 (read), io_oe is 0 during data. One line samples io_i[1]. Two lines sample io_i[1:0] and four lines sample io_i[3:0], with the high bits first in each case. The req_data_len bytes come out on rx_data in order. req_dir = 0 gives no data stage.
- R7: SPI mode 0. sck is low whenever cs_n is high. io_o changes only while sck is low, and inputs are sampled on the rising sck edge.
- R8: cs_n falls when a request is accepted, before the first rising sck edge, and rises after the last falling edge. busy equals the inverse of cs_n. req_ready then stays low for exactly CS_GAP (default 2) system clocks after cs_n rises.
- R9: When a write byte is due and tx_valid is low, sck stays low, no clocks are given and cs_n stays low until tx_valid returns.
- R10: When rx_valid is high and rx_ready is low, rx_valid and rx_data hold. After the following byte has been received, sck stops until that byte can be delivered.
- R11: A transaction gives exactly the sum over its stages of bytes × 8 / width rising sck edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_opcode | input | 8 | Command byte |
| req_addr | input | 24 | Address, right-aligned |
| req_addr_bytes | input | 2 | Address byte count, 0 to 3 |
| req_addr_lanes | input | 2 | Address width code |
| req_dummy_bytes | input | 4 | Dummy byte count |
| req_dummy_lanes | input | 2 | Dummy width code |
| req_dir | input | 2 | Data direction: 0 none, 1 read, 2 write |
| req_data_lanes | input | 2 | Data width code |
| req_data_len | input | 8 | Data byte count |
| busy | output | 1 | Transaction in progress |
| tx_data | input | 8 | Write byte |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Write byte taken |
| rx_data | output | 8 | Read byte |
| rx_valid | output | 1 | Read byte available |
| rx_ready | input | 1 | Read byte taken |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| io_o | output | 4 | IO line output values |
| io_oe | output | 4 | IO line output enables |
| io_i | input | 4 | IO line inputs |

## Verification
A stage counter that runs on or stops short would change the number of rising sck edges within the same transaction. A shift register packed the wrong way round, or a width code applied to the wrong stage, would misplace bits on the first clock after the fault, where the bench compares every sampled IO value against its own expected map. A wrongly released or wrongly driven line would show in io_oe on the same edge. Stream stalls that are not held would appear within one byte time, either as clocks during a stall or as a changed rx_data.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

  // width codes for a stage
  typedef enum logic [1:0] {LN1 = 2'd0, LN2 = 2'd1, LN4 = 2'd2} lane_e;
  typedef enum logic [1:0] {DIR_NONE = 2'd0, DIR_IN = 2'd1, DIR_OUT = 2'd2} dir_e;
  typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA, PH_DONE} phase_e;
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_RXPUSH, S_GAP} seq_state_e;

  // serial clocks needed for one byte at a given width
  function automatic logic [3:0] beats_per_byte(lane_e l);
    case (l)
      LN1:     return 4'd8;
      LN2:     return 4'd4;
      default: return 4'd2;
    endcase
  endfunction

  // output shift by one beat
  function automatic logic [7:0] shift_beat(logic [7:0] sh, lane_e l);
    case (l)
      LN1:     return {sh[6:0], 1'b0};
      LN2:     return {sh[5:0], 2'b00};
      default: return {sh[3:0], 4'h0};
    endcase
  endfunction

  // lines in use at a given width
  function automatic logic [3:0] lane_mask(lane_e l);
    case (l)
      LN1:     return 4'b0001;
      LN2:     return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/qspi_sck_div.sv
module qspi_sck_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/qspi_lane_io.sv
module qspi_lane_io
  import qspi_seq_pkg::*;
(
  input  logic [7:0] sh,
  input  lane_e      lanes,
  input  logic       drive,
  input  logic [7:0] insh,
  input  logic [3:0] io_i,
  output logic [3:0] io_o,
  output logic [3:0] io_oe,
  output logic [7:0] in_next
);
  always_comb begin
    case (lanes)
      LN1: begin
        io_o    = {3'b000, sh[7]};
        in_next = {insh[6:0], io_i[1]};
      end
      LN2: begin
        io_o    = {2'b00, sh[7:6]};
        in_next = {insh[5:0], io_i[1:0]};
      end
      default: begin
        io_o    = sh[7:4];
        in_next = {insh[3:0], io_i};
      end
    endcase
    io_oe = drive ? lane_mask(lanes) : 4'b0000;
  end
endmodule

// File: rtl/qspi_phase_seq.sv
module qspi_phase_seq
  import qspi_seq_pkg::*;
#(
  parameter int HALF       = 2,
  parameter int ADDR_BYTES = 3,
  parameter int LEN_W      = 8,
  parameter int DUM_W      = 4,
  parameter int CS_GAP     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [7:0]                    req_opcode,
  input  logic [8*ADDR_BYTES-1:0]       req_addr,
  input  logic [$clog2(ADDR_BYTES+1)-1:0] req_addr_bytes,
  input  logic [1:0]                    req_addr_lanes,
  input  logic [DUM_W-1:0]              req_dummy_bytes,
  input  logic [1:0]                    req_dummy_lanes,
  input  logic [1:0]                    req_dir,
  input  logic [1:0]                    req_data_lanes,
  input  logic [LEN_W-1:0]              req_data_len,
  output logic                          busy,
  input  logic [7:0]                    tx_data,
  input  logic                          tx_valid,
  output logic                          tx_ready,
  output logic [7:0]                    rx_data,
  output logic                          rx_valid,
  input  logic                          rx_ready,
  output logic                          cs_n,
  output logic                          sck,
  output logic [3:0]                    io_o,
  output logic [3:0]                    io_oe,
  input  logic [3:0]                    io_i
);
  localparam int AW    = 8 * ADDR_BYTES;
  localparam int AB_W  = $clog2(ADDR_BYTES + 1);
  localparam int CNT_W = (LEN_W > DUM_W) ? LEN_W : DUM_W;
  localparam int GAP_W = $clog2(CS_GAP + 1);

  seq_state_e        st;
  phase_e            ph;
  logic [CNT_W-1:0]  brem;
  logic [7:0]        r_op;
  logic [AW-1:0]     r_addr;
  logic [AB_W-1:0]   r_ab;
  lane_e             r_al, r_dl, r_ll;
  logic [DUM_W-1:0]  r_db;
  dir_e              r_dir;
  logic [LEN_W-1:0]  r_len;
  logic [7:0]        sh, insh, rxd;
  lane_e             lanes;
  logic              drive, sck_q, cs_q, rxv;
  logic [3:0]        beats;
  logic [GAP_W-1:0]  gap;

  // named events for assertions and readability
  logic              tick, rx_push, load_stall, load_drive;
  logic [7:0]        load_byte, in_next;
  lane_e             load_lanes;
  logic [CNT_W-1:0]  next_cnt;

  qspi_sck_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(st == S_SHIFT), .tick(tick)
  );

  qspi_lane_io u_lane (
    .sh(sh), .lanes(lanes), .drive(drive), .insh(insh), .io_i(io_i),
    .io_o(io_o), .io_oe(io_oe), .in_next(in_next)
  );

  assign req_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE) && (st != S_GAP);
  assign cs_n      = cs_q;
  assign sck       = sck_q;
  assign rx_data   = rxd;
  assign rx_valid  = rxv;
  assign rx_push   = (st == S_RXPUSH) && (!rxv || rx_ready);
  assign tx_ready  = (st == S_LOAD) && (ph == PH_DATA) && (r_dir == DIR_OUT)
                     && (brem != '0) && tx_valid;

  always_comb begin
    case (ph)
      PH_OPC:   next_cnt = CNT_W'(r_ab);
      PH_ADDR:  next_cnt = CNT_W'(r_db);
      PH_DUMMY: next_cnt = (r_dir == DIR_NONE) ? '0 : CNT_W'(r_len);
      default:  next_cnt = '0;
    endcase
    load_stall = (ph == PH_DATA) && (r_dir == DIR_OUT) && !tx_valid;
    case (ph)
      PH_OPC:   begin load_byte = r_op;               load_lanes = LN1;  load_drive = 1'b1; end
      PH_ADDR:  begin load_byte = r_addr[AW-1 -: 8];  load_lanes = r_al; load_drive = 1'b1; end
      PH_DUMMY: begin load_byte = 8'h00;              load_lanes = r_dl; load_drive = 1'b0; end
      default:  begin
        load_byte  = (r_dir == DIR_OUT) ? tx_data : 8'h00;
        load_lanes = r_ll;
        load_drive = (r_dir == DIR_OUT);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_DONE; brem <= '0;
      r_op <= '0; r_addr <= '0; r_ab <= '0; r_db <= '0; r_len <= '0;
      r_al <= LN1; r_dl <= LN1; r_ll <= LN1; r_dir <= DIR_NONE;
      sh <= '0; insh <= '0; rxd <= '0; rxv <= 1'b0;
      lanes <= LN1; drive <= 1'b0; sck_q <= 1'b0; cs_q <= 1'b1;
      beats <= '0; gap <= '0;
    end else begin
      if (rx_push) begin
        rxd <= insh;
        rxv <= 1'b1;
      end else if (rx_ready) begin
        rxv <= 1'b0;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          r_op   <= req_opcode;
          r_addr <= AW'(req_addr << (8 * (ADDR_BYTES - int'(req_addr_bytes))));
          r_ab   <= req_addr_bytes;
          r_al   <= lane_e'(req_addr_lanes);
          r_db   <= req_dummy_bytes;
          r_dl   <= lane_e'(req_dummy_lanes);
          r_dir  <= dir_e'(req_dir);
          r_ll   <= lane_e'(req_data_lanes);
          r_len  <= req_data_len;
          ph     <= PH_OPC;
          brem   <= CNT_W'(1);
          cs_q   <= 1'b0;
          st     <= S_LOAD;
        end
        S_LOAD: begin
          if (ph == PH_DONE) begin
            cs_q  <= 1'b1;
            drive <= 1'b0;
            gap   <= GAP_W'(CS_GAP - 1);
            st    <= S_GAP;
          end else if (brem == '0) begin
            ph   <= phase_e'(ph + 3'd1);
            brem <= next_cnt;
          end else if (!load_stall) begin
            sh    <= load_byte;
            lanes <= load_lanes;
            drive <= load_drive;
            beats <= beats_per_byte(load_lanes);
            if (ph == PH_ADDR) r_addr <= r_addr << 8;
            st    <= S_SHIFT;
          end
        end
        S_SHIFT: if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            insh  <= in_next;
          end else begin
            sck_q <= 1'b0;
            if (beats != 4'd1) begin
              beats <= beats - 4'd1;
              sh    <= shift_beat(sh, lanes);
            end else begin
              brem <= brem - 1'b1;
              st   <= (ph == PH_DATA && r_dir == DIR_IN) ? S_RXPUSH : S_LOAD;
            end
          end
        end
        S_RXPUSH: if (rx_push) st <= S_LOAD;
        S_GAP: begin
          if (gap == '0) st <= S_IDLE;
          else           gap <= gap - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7: serial clock parked low outside a transaction
  p_sck_low_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  // R7: data lines hold while the clock is high
  p_io_stable_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> ($stable(io_o) && $stable(io_oe)));
  // R8: busy tracks chip select
  p_busy_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);
  // R8: no new request right after chip select rises
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !req_ready);
  // R5: write bytes are only taken inside a transaction, clock low
  p_tx_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!cs_n && !sck));
  // R10: a read byte that is not taken holds
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

// File: tb/qspi_phase_seq_tb.sv
module qspi_phase_seq_tb;
  localparam int NV = 11;
  localparam int MAXB = 512;

  // fields: op[53:46] addr[45:22] ab[21:20] al[19:18] db[17:14] dl[13:12] dir[11:10] ll[9:8] len[7:0]
  localparam logic [53:0] VEC [NV] = '{
    {8'hFF, 24'h000000, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 2'd0, 8'd0},
    {8'h06, 24'h000000, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 2'd0, 8'd0},
    {8'h0F, 24'h0000C0, 2'd1, 2'd0, 4'd0, 2'd0, 2'd1, 2'd0, 8'd1},
    {8'h1F, 24'h0000A0, 2'd1, 2'd0, 4'd0, 2'd0, 2'd2, 2'd0, 8'd1},
    {8'h13, 24'h012345, 2'd3, 2'd0, 4'd0, 2'd0, 2'd0, 2'd0, 8'd0},
    {8'h03, 24'h000100, 2'd2, 2'd0, 4'd1, 2'd0, 2'd1, 2'd0, 8'd4},
    {8'h3B, 24'h0007E1, 2'd2, 2'd0, 4'd1, 2'd0, 2'd1, 2'd1, 8'd3},
    {8'h6B, 24'h00B6D9, 2'd2, 2'd0, 4'd1, 2'd0, 2'd1, 2'd2, 8'd5},
    {8'hBB, 24'h00C35A, 2'd2, 2'd1, 4'd1, 2'd1, 2'd1, 2'd1, 8'd2},
    {8'hEB, 24'h009E71, 2'd2, 2'd2, 4'd2, 2'd2, 2'd1, 2'd2, 8'd4},
    {8'h32, 24'h0004D2, 2'd2, 2'd0, 4'd0, 2'd0, 2'd2, 2'd2, 8'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, busy;
  logic [7:0] req_opcode = '0;
  logic [23:0] req_addr = '0;
  logic [1:0] req_addr_bytes = '0, req_addr_lanes = '0, req_dummy_lanes = '0;
  logic [3:0] req_dummy_bytes = '0;
  logic [1:0] req_dir = '0, req_data_lanes = '0;
  logic [7:0] req_data_len = '0;
  logic [7:0] tx_data, rx_data;
  logic tx_en = 1'b1, tx_valid, tx_ready, rx_valid, rx_ready = 1'b1;
  logic cs_n, sck;
  logic [3:0] io_o, io_oe, io_i = '0;

  int checks = 0, errors = 0;
  int k = 0, tx_n = 0, rx_n = 0, n_exp = 0, n_rx_exp = 0, n_tx_exp = 0, tx_base = 0;
  logic [3:0] exp_o [MAXB], exp_oe [MAXB], exp_in [MAXB], got_o [MAXB], got_oe [MAXB];
  logic [7:0] rx_got [64], exp_rx [64];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] txp(int i);
    return 8'hA5 ^ 8'(i * 59);
  endfunction
  function automatic logic [7:0] rxp(int i);
    return 8'h5C + 8'(i * 39);
  endfunction
  function automatic int nl(logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  assign tx_valid = tx_en;
  assign tx_data  = txp(tx_n);

  qspi_phase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_addr(req_addr), .req_addr_bytes(req_addr_bytes),
    .req_addr_lanes(req_addr_lanes), .req_dummy_bytes(req_dummy_bytes),
    .req_dummy_lanes(req_dummy_lanes), .req_dir(req_dir), .req_data_lanes(req_data_lanes),
    .req_data_len(req_data_len), .busy(busy), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .cs_n(cs_n), .sck(sck), .io_o(io_o), .io_oe(io_oe), .io_i(io_i)
  );

  // flash-side monitor and responder
  always @(posedge sck) begin
    if (k < MAXB) begin
      got_o[k]  <= io_o;
      got_oe[k] <= io_oe;
    end
    k <= k + 1;
  end
  always @(negedge sck) io_i <= (k < MAXB) ? exp_in[k] : 4'h0;

  always @(posedge clk) begin
    if (tx_valid && tx_ready) tx_n <= tx_n + 1;
    if (rx_valid && rx_ready) begin
      if (rx_n < 64) rx_got[rx_n] <= rx_data;
      rx_n <= rx_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic add_byte(input logic [7:0] v, input int n, input int kind);
    for (int b = 0; b < 8 / n; b++) begin
      logic [3:0] bits;
      bits = 4'((v >> (8 - n * (b + 1))) & ((1 << n) - 1));
      exp_o[n_exp]  = (kind == 0) ? bits : 4'h0;
      exp_oe[n_exp] = (kind == 0) ? 4'((1 << n) - 1) : 4'h0;
      exp_in[n_exp] = (kind == 2) ? ((n == 1) ? {bits[2:0], 1'b0} : bits) : 4'h0;
      n_exp++;
    end
  endtask

  task automatic build(input logic [53:0] v);
    n_exp = 0; n_rx_exp = 0; n_tx_exp = 0; tx_base = tx_n;
    for (int i = 0; i < MAXB; i++) exp_in[i] = 4'h0;
    add_byte(v[53:46], 1, 0);
    for (int i = 0; i < int'(v[21:20]); i++)
      add_byte(8'(v[45:22] >> (8 * (int'(v[21:20]) - 1 - i))), nl(v[19:18]), 0);
    for (int i = 0; i < int'(v[17:14]); i++) add_byte(8'h00, nl(v[13:12]), 1);
    if (v[11:10] == 2'd2)
      for (int i = 0; i < int'(v[7:0]); i++) begin
        add_byte(txp(tx_base + i), nl(v[9:8]), 0);
        n_tx_exp++;
      end
    if (v[11:10] == 2'd1)
      for (int i = 0; i < int'(v[7:0]); i++) begin
        add_byte(rxp(i), nl(v[9:8]), 2);
        exp_rx[i] = rxp(i);
        n_rx_exp++;
      end
  endtask

  task automatic start(input logic [53:0] v);
    build(v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    k = 0; rx_n = 0; io_i = exp_in[0];
    {req_opcode, req_addr, req_addr_bytes, req_addr_lanes, req_dummy_bytes,
     req_dummy_lanes, req_dir, req_data_lanes, req_data_len} = v;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !cs_n, "R8 cs_n low after accept", {31'd0, cs_n}, 0);
  endtask

  task automatic finish_chk(input int idx);
    int g, bad, rbad;
    while (busy) @(negedge clk);
    g = 0;
    while (!req_ready) begin g++; @(negedge clk); end
    check(g >= 2, $sformatf("R8 gap vec%0d", idx), g, 2);
    check(k == n_exp, $sformatf("R11 clock count vec%0d", idx), k, n_exp);
    bad = 0;
    for (int i = 0; i < n_exp && i < k; i++)
      if (got_oe[i] != exp_oe[i] || (got_o[i] & exp_oe[i]) != exp_o[i]) bad++;
    check(bad == 0, $sformatf("R2/R3/R4/R5 line map vec%0d", idx), bad, 0);
    check(tx_n - tx_base == n_tx_exp, $sformatf("R5 bytes taken vec%0d", idx),
          tx_n - tx_base, n_tx_exp);
    rbad = 0;
    for (int i = 0; i < n_rx_exp && i < rx_n; i++) if (rx_got[i] != exp_rx[i]) rbad++;
    check(rx_n == n_rx_exp && rbad == 0, $sformatf("R6 read bytes vec%0d", idx),
          rx_n * 256 + rbad, n_rx_exp * 256);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k0;
    logic [7:0] d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cs_n === 1'b1 && sck === 1'b0, "R1 cs_n/sck", {30'd0, cs_n, sck}, 2);
    check(io_oe === 4'h0 && busy === 1'b0 && rx_valid === 1'b0 && req_ready === 1'b1,
          "R1 oe/busy/rx_valid/ready", {26'd0, io_oe, busy, rx_valid, req_ready}, 1);

    // table walk: R2..R6, R8, R11
    for (int v = 0; v < NV; v++) begin
      start(VEC[v]);
      finish_chk(v);
    end

    // R9: write stream stalls before the first data byte
    tx_en = 1'b0;
    start(VEC[10]);
    while (k < 24) @(negedge clk);
    repeat (6) @(negedge clk);
    k0 = k;
    repeat (20) @(negedge clk);
    check(k == k0 && !cs_n && !sck, "R9 clock held while tx_valid low", k, k0);
    tx_en = 1'b1;
    finish_chk(100);

    // R10: read stream backpressure
    rx_ready = 1'b0;
    start(VEC[5]);
    while (!rx_valid) @(negedge clk);
    d0 = rx_data;
    check(d0 == rxp(0), "R6 first read byte", d0, rxp(0));
    repeat (70) @(negedge clk);
    k0 = k;
    repeat (12) @(negedge clk);
    check(rx_valid && rx_data == d0, "R10 rx held", rx_data, d0);
    check(k == k0 && !cs_n, "R10 clock held under backpressure", k, k0);
    rx_ready = 1'b1;
    finish_chk(101);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule